// File: doc/BRIEF.md
# External Edge Interrupt Controller

This block turns falling edges on two external input pins into interrupt requests for a small 8-bit core. Each pin passes through a synchronizer. A falling edge then sets a request flag for that source. The flag stays set until software clears it, and it latches whether or not the source is enabled. Software can therefore poll for events even when a source is masked.

The core is diverted only when three conditions hold together: a flag is set, that source's enable bit is 1, and the global enable is 1. When they do, the block raises a one-cycle take pulse and presents the shared vector address (8) on the same cycle. Taking an interrupt clears the global enable, so service routines do not nest. A return strobe from the core ends service and sets the global enable again. Because both sources share one vector, the service routine reads the flags to find the cause and clears them with a masked write.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset the flags read 0, the enables are 0, the global enable is 0, and `takePulse` is 0.
- R2: A 1-to-0 transition on `pinIn[i]` sets `flagOut[i]`. The flag reads 1 from the third rising clock edge after the pin goes low, and reads 0 after the second. A 0-to-1 transition sets no flag.
- R3: A falling edge sets its flag whether that source's enable bit is 0 or 1.
- R4: `takePulse` is raised only when at least one flag is set with its enable bit at 1. A set flag whose enable is 0 never causes a take.
- R5: No take occurs while the global enable is 0. Writing the global enable to 1 (`gieWrStb` with `gieWrData`=1) while an enabled flag is pending raises `takePulse` from the next clock edge.
- R6: During a take cycle `vectorAddr` equals 8. In every other cycle it is 0.
- R7: A take does not clear any flag. A flag is cleared only by a write with `flagClrStb`=1 in which bit i of `flagClrMask` is 1 (bit i selects source i).
- R8: `takePulse` lasts exactly one cycle. After it the global enable is 0 and the block is in service, and no further take occurs until `retStb`.
- R9: `retStb` ends service and sets the global enable to 1. An enabled flag that is still pending causes a new take on the following cycle.
- R10: When a falling edge reaches a flag in the same cycle that software clears it, the flag ends set.
- R11: A masked clear leaves the flags whose mask bits are 0 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pinIn | input | NUM_SRC | External pins, asynchronous, idle high |
| enWrStb | input | 1 | Load the per-source enable register |
| enWrData | input | NUM_SRC | New per-source enable bits |
| flagClrStb | input | 1 | Clear the flags selected by the mask |
| flagClrMask | input | NUM_SRC | 1 = clear that source's flag |
| gieWrStb | input | 1 | Write the global enable |
| gieWrData | input | 1 | New global enable value |
| retStb | input | 1 | Return from interrupt |
| flagOut | output | NUM_SRC | Sticky request flags |
| takePulse | output | 1 | One-cycle interrupt take |
| vectorAddr | output | VEC_W | Vector address during a take, else 0 |

## Verification
The assertions check, on every cycle, the rules that hold locally:
- a take is one cycle long and needs an enabled, set flag;
- no take occurs while the block is in service;
- the vector address is valid exactly when a take is raised;
- a take leaves the global enable cleared;
- a set flag survives any cycle without a matching clear.

Only the bench's scenarios can show the rest:
- the edge-to-flag latency through the synchronizer;
- that a rising edge sets nothing;
- the retake after return while a flag is still pending;
- that a new edge beats a simultaneous clear.

// File: rtl/eic_pkg.sv
package eic_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic enLoad;
    logic flagClr;
  } eicStrobe_t;
endpackage

// File: rtl/eic_pin_sync.sv
module eic_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic pinIn,
  output logic pinSync
);
  logic [STAGES-1:0] chain;

  // Reset to the idle-high level so that leaving reset makes no false edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '1;
    else       chain <= {chain[STAGES-2:0], pinIn};
  end

  assign pinSync = chain[STAGES-1];
endmodule

// File: rtl/eic_datapath.sv
module eic_datapath
  import eic_pkg::*;
#(
  parameter int NUM_SRC     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] pinIn,
  input  eicStrobe_t         strb,
  input  logic [NUM_SRC-1:0] enData,
  input  logic [NUM_SRC-1:0] clrMask,
  output logic [NUM_SRC-1:0] flagQ,
  output logic [NUM_SRC-1:0] enQ,
  output logic               pendingAny
);
  logic [NUM_SRC-1:0] pinSync;
  logic [NUM_SRC-1:0] prevQ;
  logic [NUM_SRC-1:0] fallEdge;
  logic [NUM_SRC-1:0] clrEff;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    eic_pin_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk    (clk),
      .rstN   (rstN),
      .pinIn  (pinIn[i]),
      .pinSync(pinSync[i])
    );
    assign fallEdge[i] = prevQ[i] & ~pinSync[i];
  end

  assign clrEff = strb.flagClr ? clrMask : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevQ <= '1;
      flagQ <= '0;
      enQ   <= '0;
    end else begin
      prevQ <= pinSync;
      // A new edge wins over a clear in the same cycle
      flagQ <= (flagQ & ~clrEff) | fallEdge;
      if (strb.enLoad) enQ <= enData;
    end
  end

  assign pendingAny = |(flagQ & enQ);
endmodule

// File: rtl/eic_control.sv
module eic_control
  import eic_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enWrStb,
  input  logic       flagClrStb,
  input  logic       gieWrStb,
  input  logic       gieWrData,
  input  logic       retStb,
  input  logic       pendingAny,
  output eicStrobe_t strb,
  output logic       take,
  output logic       gieQ,
  output logic       inSvc
);
  assign strb.enLoad  = enWrStb;
  assign strb.flagClr = flagClrStb;

  assign take = pendingAny & gieQ & ~inSvc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gieQ  <= 1'b0;
      inSvc <= 1'b0;
    end else if (take) begin
      gieQ  <= 1'b0;
      inSvc <= 1'b1;
    end else if (retStb) begin
      gieQ  <= 1'b1;
      inSvc <= 1'b0;
    end else if (gieWrStb) begin
      gieQ  <= gieWrData;
    end
  end
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import eic_pkg::*;
#(
  parameter int NUM_SRC     = 2,
  parameter int SYNC_STAGES = 2,
  parameter int VEC_W       = 8,
  parameter int VECTOR_ADDR = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] pinIn,
  input  logic               enWrStb,
  input  logic [NUM_SRC-1:0] enWrData,
  input  logic               flagClrStb,
  input  logic [NUM_SRC-1:0] flagClrMask,
  input  logic               gieWrStb,
  input  logic               gieWrData,
  input  logic               retStb,
  output logic [NUM_SRC-1:0] flagOut,
  output logic               takePulse,
  output logic [VEC_W-1:0]   vectorAddr
);
  localparam logic [VEC_W-1:0] VecConst = VEC_W'(VECTOR_ADDR);

  eicStrobe_t         strb;
  logic               pendingAny;
  logic [NUM_SRC-1:0] enQ;
  logic               gieQ;
  logic               inSvc;

  eic_datapath #(.NUM_SRC(NUM_SRC), .SYNC_STAGES(SYNC_STAGES)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .pinIn     (pinIn),
    .strb      (strb),
    .enData    (enWrData),
    .clrMask   (flagClrMask),
    .flagQ     (flagOut),
    .enQ       (enQ),
    .pendingAny(pendingAny)
  );

  eic_control ctl_i (
    .clk       (clk),
    .rstN      (rstN),
    .enWrStb   (enWrStb),
    .flagClrStb(flagClrStb),
    .gieWrStb  (gieWrStb),
    .gieWrData (gieWrData),
    .retStb    (retStb),
    .pendingAny(pendingAny),
    .strb      (strb),
    .take      (takePulse),
    .gieQ      (gieQ),
    .inSvc     (inSvc)
  );

  assign vectorAddr = takePulse ? VecConst : '0;
endmodule

// File: rtl/eic_checker.sv
module eic_checker #(
  parameter int NUM_SRC     = 2,
  parameter int VEC_W       = 8,
  parameter int VECTOR_ADDR = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               takePulse,
  input logic [VEC_W-1:0]   vectorAddr,
  input logic [NUM_SRC-1:0] flagOut,
  input logic               flagClrStb,
  input logic [NUM_SRC-1:0] flagClrMask,
  input logic [NUM_SRC-1:0] enQ,
  input logic               gieQ,
  input logic               inSvc
);
  logic [NUM_SRC-1:0] keep;
  assign keep = flagOut & ~(flagClrStb ? flagClrMask : '0);

  p_take_one_cycle_r8: assert property (@(posedge clk) disable iff (!rstN)
    takePulse |=> !takePulse);

  p_take_enters_service_r8: assert property (@(posedge clk) disable iff (!rstN)
    takePulse |=> (inSvc && !gieQ));

  p_no_take_in_service_r8: assert property (@(posedge clk) disable iff (!rstN)
    inSvc |-> !takePulse);

  p_take_enabled_r4: assert property (@(posedge clk) disable iff (!rstN)
    takePulse |-> (|(flagOut & enQ)));

  p_take_needs_gie_r5: assert property (@(posedge clk) disable iff (!rstN)
    takePulse |-> gieQ);

  p_vector_on_take_r6: assert property (@(posedge clk) disable iff (!rstN)
    takePulse |-> (vectorAddr == VEC_W'(VECTOR_ADDR)));

  p_vector_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    !takePulse |-> (vectorAddr == '0));

  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    (|keep) |=> ((flagOut & $past(keep)) == $past(keep)));
endmodule

bind ext_irq_ctrl eic_checker #(
  .NUM_SRC(NUM_SRC), .VEC_W(VEC_W), .VECTOR_ADDR(VECTOR_ADDR)
) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .takePulse  (takePulse),
  .vectorAddr (vectorAddr),
  .flagOut    (flagOut),
  .flagClrStb (flagClrStb),
  .flagClrMask(flagClrMask),
  .enQ        (enQ),
  .gieQ       (gieQ),
  .inSvc      (inSvc)
);

// File: tb/ext_irq_ctrl_tb.sv
module ext_irq_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] pinIn = 2'b11;
  logic       enWrStb = 1'b0;
  logic [1:0] enWrData = '0;
  logic       flagClrStb = 1'b0;
  logic [1:0] flagClrMask = '0;
  logic       gieWrStb = 1'b0;
  logic       gieWrData = 1'b0;
  logic       retStb = 1'b0;
  logic [1:0] flagOut;
  logic       takePulse;
  logic [7:0] vectorAddr;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ext_irq_ctrl dut_i (
    .clk(clk), .rstN(rstN), .pinIn(pinIn),
    .enWrStb(enWrStb), .enWrData(enWrData),
    .flagClrStb(flagClrStb), .flagClrMask(flagClrMask),
    .gieWrStb(gieWrStb), .gieWrData(gieWrData), .retStb(retStb),
    .flagOut(flagOut), .takePulse(takePulse), .vectorAddr(vectorAddr)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic writeEn(input logic [1:0] v);
    enWrStb = 1'b1; enWrData = v; step(); enWrStb = 1'b0;
  endtask

  task automatic writeGie(input logic v);
    gieWrStb = 1'b1; gieWrData = v; step(); gieWrStb = 1'b0;
  endtask

  task automatic clearFlags(input logic [1:0] m);
    flagClrStb = 1'b1; flagClrMask = m; step(); flagClrStb = 1'b0; flagClrMask = '0;
  endtask

  task automatic doReturn();
    retStb = 1'b1; step(); retStb = 1'b0;
  endtask

  task automatic t_reset();
    chk(flagOut == 2'b00, "R1", "flags after reset", flagOut, 0);
    chk(takePulse == 1'b0, "R1", "take after reset", takePulse, 0);
    chk(vectorAddr == 8'd0, "R6", "vector idle", vectorAddr, 0);
    step(4);
    chk(takePulse == 1'b0, "R1", "no take with gie 0 after reset", takePulse, 0);
  endtask

  // Masked source: flag latches, no take; edge latency; rising edge ignored
  task automatic t_masked_edge();
    writeEn(2'b00);
    writeGie(1'b1);
    pinIn[0] = 1'b0;
    step(2);
    chk(flagOut[0] == 1'b0, "R2", "flag not yet set after 2 edges", flagOut[0], 0);
    step();
    chk(flagOut[0] == 1'b1, "R3", "flag set with enable 0", flagOut[0], 1);
    chk(takePulse == 1'b0, "R4", "no take with enable 0", takePulse, 0);
    step(3);
    chk(takePulse == 1'b0, "R4", "still no take", takePulse, 0);
    clearFlags(2'b01);
    chk(flagOut == 2'b00, "R7", "flag cleared by write", flagOut, 0);
    pinIn[0] = 1'b1;
    step(5);
    chk(flagOut == 2'b00, "R2", "rising edge sets nothing", flagOut, 0);
    writeGie(1'b0);
  endtask

  // Global enable gating, take, service, return and retake
  task automatic t_gie_take();
    writeEn(2'b11);
    pinIn[1] = 1'b0;
    step(3);
    chk(flagOut == 2'b10, "R3", "flag1 set", flagOut, 2);
    step(3);
    chk(takePulse == 1'b0, "R5", "no take with gie 0", takePulse, 0);
    writeGie(1'b1);
    chk(takePulse == 1'b1, "R5", "take after gie write", takePulse, 1);
    chk(vectorAddr == 8'd8, "R6", "vector during take", vectorAddr, 8);
    step();
    chk(takePulse == 1'b0, "R8", "take is one cycle", takePulse, 0);
    chk(flagOut == 2'b10, "R7", "take leaves flag set", flagOut, 2);
    writeGie(1'b1);
    step(3);
    chk(takePulse == 1'b0, "R8", "no take while in service", takePulse, 0);
    doReturn();
    chk(takePulse == 1'b1, "R9", "retake after return", takePulse, 1);
    step();
    chk(takePulse == 1'b0, "R8", "retake is one cycle", takePulse, 0);
    clearFlags(2'b10);
    doReturn();
    step(2);
    chk(takePulse == 1'b0, "R9", "no take once flag cleared", takePulse, 0);
    chk(flagOut == 2'b00, "R7", "flags cleared", flagOut, 0);
    pinIn[1] = 1'b1;
    step(4);
    writeGie(1'b0);
  endtask

  // Edge coinciding with clear; masked clear keeps the other bit
  task automatic t_clear_race();
    writeEn(2'b00);
    pinIn = 2'b00;
    step(3);
    chk(flagOut == 2'b11, "R3", "both flags set", flagOut, 3);
    pinIn[0] = 1'b1;
    step(4);
    pinIn[0] = 1'b0;
    step(2);
    flagClrStb = 1'b1; flagClrMask = 2'b01;
    step();
    flagClrStb = 1'b0; flagClrMask = '0;
    chk(flagOut[0] == 1'b1, "R10", "edge wins over clear", flagOut[0], 1);
    chk(flagOut[1] == 1'b1, "R11", "unmasked flag kept", flagOut[1], 1);
    clearFlags(2'b10);
    chk(flagOut == 2'b01, "R11", "only bit1 cleared", flagOut, 1);
    clearFlags(2'b01);
    chk(flagOut == 2'b00, "R7", "all cleared", flagOut, 0);
    pinIn = 2'b11;
    step(4);
  endtask

  initial begin
    step(3);
    rstN = 1'b1;
    step();
    t_reset();
    t_masked_edge();
    t_gie_take();
    t_clear_race();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule